// File: doc/BRIEF.md
# Integrity-MAC Final Block Padder

This block sits on the message path in front of a 64-bit integrity engine. Message blocks come in over a valid/ready handshake, big-endian: the first message bit is in the most significant bit. A total message length in bits, a padding-enable control and a direction bit travel alongside the data. They are only used on the handshake that carries the final block, which is marked by `in_last`. Blocks before the final one pass through unchanged.

With padding enabled, the final block keeps its valid message bits and clears everything after them. The direction bit follows the last valid bit, then a single one, then zeros out to the block boundary. When these marker bits do not fit in the final block, a further block is produced for them. With padding disabled, the final block passes through as it is. A length that is not a whole number of blocks then raises a sticky error flag.

A done flag records that the last output block of a message has been accepted downstream. A clear pulse resets both the done flag and the error flag.

Top module: `mac_tail_padder`

## Requirements
- R1: A block accepted with `in_last`=0 is emitted unchanged with `out_last`=0.
- R2: With `pad_en`=1, the remainder r is the message length in bits modulo 64. For r between 1 and 62, the final block produces exactly one output block with `out_last`=1. Bits 63 down to 64-r hold the message bits. Bit 63-r holds the direction bit. Bit 62-r is 1. All lower bits are 0.
- R3: In a padded final block, input bits at positions below 64-r are replaced, whatever their value.
- R4: With `pad_en`=1 and r=63, the final block is emitted with its 63 message bits and the direction bit in bit 0, and `out_last`=0. It is followed by the block 0x8000_0000_0000_0000 with `out_last`=1.
- R5: With `pad_en`=1 and r=0, the final block is emitted unchanged with `out_last`=0. It is followed by one block with the direction bit in bit 63, a 1 in bit 62, zeros below, and `out_last`=1.
- R6: With `pad_en`=0, the final block is emitted unchanged with `out_last`=1. If r is not 0, `err` becomes 1 on the cycle after that handshake.
- R7: `err` stays 1 until a cycle with `clr`=1. That cycle returns both `err` and `done` to 0 on the next cycle, even if a setting event happens in the same cycle.
- R8: `done` becomes 1 on the cycle after an output handshake with `out_last`=1. It is 0 after reset.
- R9: While `out_valid`=1 and `out_ready`=0, the output data and `out_last` hold steady and `in_ready` is 0. `in_ready` is also 0 while a second padding block is still waiting.
- R10: `pad_en`, `dir_bit` and `msg_bits` are used only from the handshake of the final block. Their values on other blocks, and after that handshake, do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block accepted when high together with in_valid |
| in_data | input | 64 | Input block, first message bit in bit 63 |
| in_last | input | 1 | Marks the final block of a message |
| msg_bits | input | 32 | Total message length in bits |
| pad_en | input | 1 | Padding enable for the final block |
| dir_bit | input | 1 | Direction bit inserted by padding |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 64 | Output block |
| out_last | output | 1 | Marks the last output block of a message |
| clr | input | 1 | Clears done and err |
| done | output | 1 | Sticky: last output block was accepted |
| err | output | 1 | Sticky: unpadded message length was not a multiple of 64 |

## Verification
The properties assume a well-behaved upstream. `in_data`, `in_last` and the side controls are sampled only on the handshake cycle. The input is not required to stay stable while stalled, because the checker relates the output only to values taken at an accepted handshake. The stimulus holds every input block until it is accepted. It drives `out_ready` randomly, or holds it high, so that both the stalled and the free-running output paths occur.

The side controls are randomised on non-final blocks and again right after the final handshake. This keeps only the values at the final handshake meaningful. Random data fills the bits past the message length, so the zero-forcing of those bits is exercised on every padded message. The remainder values 0, 1, 62 and 63 are driven as directed cases, because they change the number of output blocks or the position of the markers.

// File: rtl/tailpad_pkg.sv
package tailpad_pkg;
   // Which kind of block the former produces for a given final-block case
   typedef enum logic [1:0] {
      TP_PASS   = 2'd0,
      TP_INLINE = 2'd1,
      TP_SPILL  = 2'd2,
      TP_WHOLE  = 2'd3
   } tp_case_e;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tailpad_former.sv
module tailpad_former
   import tailpad_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] blk_i,
   input  logic [IDX_W-1:0]  rem_i,
   input  logic              last_i,
   input  logic              pad_i,
   input  logic              dir_i,
   output logic [DATA_W-1:0] first_o,
   output logic              first_last_o,
   output logic              need_extra_o,
   output logic [DATA_W-1:0] extra_o,
   output logic              len_fault_o
);
   localparam logic [IDX_W-1:0] REM_TOP = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] padded;
   logic [IDX_W:0]    rem_plus;
   tp_case_e          kind;

   assign rem_plus = {1'b0, rem_i} + (IDX_W+1)'(1);

   // One cell per bit; p counts from the MSB (first message bit) downward
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam int P = DATA_W - 1 - i;
      logic keep_b, dir_b, one_b;
      assign keep_b = (IDX_W'(P) < rem_i);
      assign dir_b  = (IDX_W'(P) == rem_i);
      assign one_b  = ((IDX_W+1)'(P) == rem_plus);
      assign padded[i] = keep_b ? blk_i[i] : (dir_b ? dir_i : one_b);
   end

   always_comb begin
      if (!last_i || !pad_i)         kind = TP_PASS;
      else if (rem_i == '0)          kind = TP_WHOLE;
      else if (rem_i == REM_TOP)     kind = TP_SPILL;
      else                           kind = TP_INLINE;
   end

   always_comb begin
      first_o      = blk_i;
      first_last_o = last_i;
      need_extra_o = 1'b0;
      extra_o      = '0;
      unique case (kind)
         TP_PASS: ;
         TP_INLINE: first_o = padded;
         TP_SPILL: begin
            first_o      = padded;
            first_last_o = 1'b0;
            need_extra_o = 1'b1;
            extra_o[DATA_W-1] = 1'b1;
         end
         TP_WHOLE: begin
            first_last_o = 1'b0;
            need_extra_o = 1'b1;
            extra_o[DATA_W-1] = dir_i;
            extra_o[DATA_W-2] = 1'b1;
         end
         default: ;
      endcase
   end

   assign len_fault_o = last_i && !pad_i && (rem_i != '0);
endmodule

// File: rtl/tailpad_flags.sv
module tailpad_flags #(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic done_set_i,
   input  logic err_set_i,
   output logic done_o,
   output logic err_o
);
   logic done_n, err_n;

   if (CLR_WINS) begin : g_clr_first
      assign done_n = clr_i ? 1'b0 : (done_o | done_set_i);
      assign err_n  = clr_i ? 1'b0 : (err_o  | err_set_i);
   end else begin : g_set_first
      assign done_n = (done_o & ~clr_i) | done_set_i;
      assign err_n  = (err_o  & ~clr_i) | err_set_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= done_n;
         err_o  <= err_n;
      end
   end
endmodule

// File: rtl/tailpad_outstage.sv
module tailpad_outstage #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] first_i,
   input  logic              first_last_i,
   input  logic              need_extra_i,
   input  logic [DATA_W-1:0] extra_i,
   input  logic              pop_i,
   output logic              hold_v_o,
   output logic [DATA_W-1:0] hold_d_o,
   output logic              hold_l_o,
   output logic              spill_pend_o
);
   logic [DATA_W-1:0] spill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v_o     <= 1'b0;
         hold_d_o     <= '0;
         hold_l_o     <= 1'b0;
         spill_pend_o <= 1'b0;
         spill_q      <= '0;
      end else if (load_i) begin
         hold_v_o     <= 1'b1;
         hold_d_o     <= first_i;
         hold_l_o     <= first_last_i;
         spill_pend_o <= need_extra_i;
         spill_q      <= extra_i;
      end else if (pop_i) begin
         if (spill_pend_o) begin
            hold_d_o     <= spill_q;
            hold_l_o     <= 1'b1;
            spill_pend_o <= 1'b0;
         end else begin
            hold_v_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mac_tail_padder.sv
module mac_tail_padder
   import tailpad_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int LEN_W    = 32,
   parameter bit CLR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic [LEN_W-1:0]  msg_bits,
   input  logic              pad_en,
   input  logic              dir_bit,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   input  logic              clr,
   output logic              done,
   output logic              err
);
   localparam int IDX_W = $clog2(DATA_W);

   if (!is_pow2(DATA_W) || DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 8");
   end
   if (LEN_W <= IDX_W) begin : g_bad_len
      $error("LEN_W must exceed log2(DATA_W)");
   end

   logic [DATA_W-1:0] first_w, extra_w;
   logic              first_last_w, need_extra_w, len_fault_w;
   logic              in_fire, out_fire, spill_pend;

   assign in_fire  = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;
   assign in_ready = !spill_pend && (!out_valid || out_ready);

   tailpad_former #(.DATA_W(DATA_W)) u_former (
      .blk_i        (in_data),
      .rem_i        (msg_bits[IDX_W-1:0]),
      .last_i       (in_last),
      .pad_i        (pad_en),
      .dir_i        (dir_bit),
      .first_o      (first_w),
      .first_last_o (first_last_w),
      .need_extra_o (need_extra_w),
      .extra_o      (extra_w),
      .len_fault_o  (len_fault_w)
   );

   tailpad_outstage #(.DATA_W(DATA_W)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (in_fire),
      .first_i      (first_w),
      .first_last_i (first_last_w),
      .need_extra_i (need_extra_w),
      .extra_i      (extra_w),
      .pop_i        (out_fire),
      .hold_v_o     (out_valid),
      .hold_d_o     (out_data),
      .hold_l_o     (out_last),
      .spill_pend_o (spill_pend)
   );

   tailpad_flags #(.CLR_WINS(CLR_WINS)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .done_set_i (out_fire && out_last),
      .err_set_i  (in_fire && len_fault_w),
      .done_o     (done),
      .err_o      (err)
   );
endmodule

// File: rtl/tailpad_checker.sv
module tailpad_checker #(
   parameter int DATA_W   = 64,
   parameter int LEN_W    = 32,
   parameter bit CLR_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              in_last,
   input logic [LEN_W-1:0]  msg_bits,
   input logic              pad_en,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              clr,
   input logic              done,
   input logic              err,
   input logic              spill_pend
);
   localparam int IDX_W = $clog2(DATA_W);

   logic in_fire, out_fire;
   assign in_fire  = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire && (!in_last || !pad_en) |=> out_valid && out_data == $past(in_data) && out_last == $past(in_last)); // R1
   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R9
   AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) || spill_pend |-> !in_ready); // R9
   AST_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire && in_last && !pad_en && msg_bits[IDX_W-1:0] != '0 && !clr |=> err); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err && !clr |=> err); // R7
   AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_last && !clr |=> done); // R8
   AST_SPILL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      spill_pend |-> out_valid && !out_last); // R4

   if (CLR_WINS) begin : g_clr_chk
      AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> !done && !err); // R7
   end
endmodule

bind mac_tail_padder tailpad_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CLR_WINS(CLR_WINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
   .in_last(in_last), .msg_bits(msg_bits), .pad_en(pad_en), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .clr(clr),
   .done(done), .err(err), .spill_pend(spill_pend)
);

// File: tb/mac_tail_padder_test.sv
module mac_tail_padder_test;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 64;
   localparam int LW = 32;
   localparam int QD = 1024;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0, pad_en = 1'b0, dir_bit = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [LW-1:0] msg_bits = '0;
   logic out_ready = 1'b0, clr = 1'b0;
   logic in_ready, out_valid, out_last, done, err;
   logic [W-1:0] out_data;

   int total = 0, bad = 0;
   logic [W-1:0] eq_d [QD];
   logic         eq_l [QD];
   string        eq_t [QD];
   int eq_wr = 0, eq_rd = 0;
   bit stall_mode = 1'b0;
   bit err_exp = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_tail_padder #(.DATA_W(W), .LEN_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .msg_bits(msg_bits), .pad_en(pad_en),
      .dir_bit(dir_bit), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .clr(clr), .done(done), .err(err)
   );

   function automatic logic [W-1:0] exp_pad(logic [W-1:0] d, int r, logic dv);
      logic [W-1:0] v;
      v = (r == 0) ? '0 : (d & ~({W{1'b1}} >> r));
      if (dv) v = v | (64'd1 << (63 - r));
      if (r < 63) v = v | (64'd1 << (62 - r));
      return v;
   endfunction

   task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(logic [W-1:0] d, logic l, string t);
      eq_d[eq_wr % QD] = d; eq_l[eq_wr % QD] = l; eq_t[eq_wr % QD] = t;
      eq_wr++;
   endtask

   // Output monitor: ready is driven at the falling edge, the handshake is judged just after
   initial begin : monitor
      logic         hv;
      logic [W-1:0] hd;
      logic         hl;
      hv = 1'b0; hd = '0; hl = 1'b0;
      forever begin
         @(negedge clk);
         out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
         #1;
         if (rst_n) begin
            if (hv) check(out_valid && out_data == hd && out_last == hl, "R9 stall hold", out_data, hd);
            if (out_valid && out_ready) begin
               if (eq_rd == eq_wr) check(1'b0, "R1 unexpected block", out_data, '0);
               else begin
                  check(out_data == eq_d[eq_rd % QD] && out_last == eq_l[eq_rd % QD],
                        eq_t[eq_rd % QD], {out_data[W-1:1], out_last}, {eq_d[eq_rd % QD][W-1:1], eq_l[eq_rd % QD]});
                  eq_rd++;
               end
            end
            hv = out_valid && !out_ready; hd = out_data; hl = out_last;
            if (hv) check(!in_ready, "R9 input blocked", {63'd0, in_ready}, '0);
         end
      end
   end

   task automatic send(logic [W-1:0] d, logic l, logic [LW-1:0] mb, logic pe, logic dv);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_last = l;
      msg_bits = l ? mb : $urandom; pad_en = l ? pe : $urandom; dir_bit = l ? dv : $urandom;
      #2;
      while (!in_ready) begin @(negedge clk); #2; end
      @(posedge clk); #1;
      in_valid = 1'b0; in_data = $urandom; in_last = $urandom;
      msg_bits = $urandom; pad_en = $urandom; dir_bit = $urandom; // R10 noise after handshake
   endtask

   task automatic drain_and_check();
      do begin @(negedge clk); #3; end while (eq_rd != eq_wr || out_valid);
      check(done == 1'b1, "R8 done after last", {63'd0, done}, 64'd1);
      check(err == err_exp, "R6 R7 err flag", {63'd0, err}, {63'd0, err_exp});
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0; #3;
      err_exp = 1'b0;
      check(done == 1'b0 && err == 1'b0, "R7 clear", {62'd0, done, err}, '0);
   endtask

   // r = valid bits of last block (0 means a full last block), fin overrides final data
   task automatic run_msg(int nblk, int r, logic pe, logic dv, bit use_fin, logic [W-1:0] fin);
      logic [LW-1:0] mb;
      int rr;
      mb = LW'((nblk - 1) * 64 + ((r == 0) ? 64 : r));
      rr = int'(mb % 64);
      for (int b = 0; b < nblk; b++) begin
         logic [W-1:0] d;
         d = {$urandom, $urandom};
         if (b < nblk - 1) begin
            push(d, 1'b0, "R1 inner block");
            send(d, 1'b0, mb, pe, dv);
         end else begin
            if (use_fin) d = fin;
            if (!pe) begin
               push(d, 1'b1, "R6 unpadded final");
               if (rr != 0) err_exp = 1'b1;
            end else if (rr == 0) begin
               push(d, 1'b0, "R5 whole final");
               push({dv, 1'b1, 62'd0}, 1'b1, "R5 marker block");
            end else if (rr == 63) begin
               push(exp_pad(d, 63, dv), 1'b0, "R4 dir in bit0");
               push(64'h8000_0000_0000_0000, 1'b1, "R4 one block");
            end else begin
               push(exp_pad(d, rr, dv), 1'b1, "R2 R3 R10 padded final");
            end
            send(d, 1'b1, mb, pe, dv);
         end
      end
      drain_and_check();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #3;
      check(!out_valid && !done && !err && in_ready, "R8 reset state",
            {60'd0, out_valid, done, err, in_ready}, 64'd1);

      // Directed: the worked example, 15 bits, direction 1
      eq_d[0] = '0;
      push(64'hF81B_8000_0000_0000, 1'b1, "R2 worked example");
      send(64'hF81A_0000_0000_0000, 1'b1, 32'd15, 1'b1, 1'b1);
      drain_and_check();
      // Junk beyond the length must vanish
      run_msg(1, 1, 1'b1, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF); // R3
      run_msg(2, 62, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF); // R2 R3
      run_msg(1, 63, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF); // R4
      run_msg(2, 0, 1'b1, 1'b0, 1'b0, '0);                     // R5
      run_msg(3, 0, 1'b0, 1'b1, 1'b0, '0);                     // R6 no fault
      run_msg(1, 17, 1'b0, 1'b0, 1'b0, '0);                    // R6 fault
      run_msg(1, 40, 1'b1, 1'b1, 1'b0, '0);                    // R7 err still sticky
      pulse_clr();

      for (int m = 0; m < 80; m++) begin
         int r, sel;
         stall_mode = (m % 2) == 1;
         sel = $urandom % 6;
         r = (sel == 0) ? 0 : (sel == 1) ? 63 : (sel == 2) ? 1 : int'($urandom % 64);
         run_msg(1 + int'($urandom % 4), r, ($urandom % 4) != 0, $urandom, 1'b0, '0);
         if (($urandom % 3) == 0) pulse_clr();
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule